// File: doc/BRIEF.md
# Heavy Load Protection Controller

This block guards a supply while a high-current load is switched on. It powers a supply-voltage detector only for the length of a measurement. It waits a settling window before it takes the detector's result, and then switches the detector off again. A low reading, or a firmware request for heavy driving, puts the block into protection mode.

Once in protection mode, the block grants permission to drive the heavy load only after a short guard window. When firmware reports that driving has finished, a long cool-down window starts. The block returns to normal mode only when that window ends with no low-supply reading outstanding. A new drive request during the cool-down restores permission at once, with no new guard window.

Every delay is a count of pulses on a single timebase tick input, and each count is a parameter. The measurement unit runs beside the protection sequencer, so a measurement can be taken at any time, including during a cool-down, to clear or confirm a low-supply condition.

Top module: `hlp_ctrl`

## Requirements
- R1: After reset, the detector enable, the protection status and the drive permit are all 0, and the last-measured supply state is "not low".
- R2: A measurement request while no measurement runs sets the detector enable in the next cycle. The enable stays set until SETTLE_TICKS ticks have been counted, and clears one cycle after the count completes. A request during a running measurement is ignored.
- R3: The detector result (det_low_i = 1 means supply at or below the threshold) is taken only in the cycle the settling count completes. Its value at any other time has no effect.
- R4: A measurement ending with det_low_i = 1 while in normal mode sets the protection status in the next cycle. One ending with det_low_i = 0 leaves normal mode unchanged.
- R5: A heavy-load request in normal mode sets the protection status in the next cycle. If it coincides with a completing measurement, the request wins.
- R6: After protection mode is entered, the drive permit rises only after GUARD_TICKS ticks, one cycle after the last of them.
- R7: A done strobe while driving is permitted clears the permit in the next cycle and keeps protection on. Normal mode returns one cycle after COOL_TICKS further ticks.
- R8: A heavy-load request during the cool-down restores the drive permit in the next cycle, with no guard window.
- R9: If the last completed measurement reported low when the cool-down count ends, protection stays on and a fresh cool-down of COOL_TICKS ticks starts. A later measurement reporting "not low" lets the block leave protection mode.
- R10: Cycles without a tick do not advance any window. A done strobe outside the drive-permitted state, and a heavy request in the guard or drive-permitted state, have no effect.
- R11: The drive permit is never 1 while the protection status is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick_i | input | 1 | Timebase pulse; each window counts these |
| meas_req_i | input | 1 | Start a supply measurement |
| det_low_i | input | 1 | Detector result, 1 = supply at or below threshold |
| heavy_req_i | input | 1 | Firmware request for heavy driving |
| heavy_done_i | input | 1 | Firmware strobe: heavy driving finished |
| det_en_o | output | 1 | Detector power enable |
| protect_o | output | 1 | 1 while in protection mode |
| drive_ok_o | output | 1 | 1 while heavy driving is permitted |

## Verification
The bench goes after the edges of each window. A design off by one tick would raise the drive permit early or drop the detector enable before the settling count completes. It toggles det_low_i during settling: a design that samples the detector early would enter protection on a stale reading. It ends a cool-down with a low reading outstanding, where a faulty design would leave protection early. It also requests driving during the cool-down, where a faulty design would impose a new guard window. Long random stretches compare every output each cycle against a behavioural model. These catch wrong priority between a request and a measurement, and strobes that are acted on in the wrong state.

// File: rtl/hlp_pkg.sv
package hlp_pkg;
  typedef enum logic [1:0] {
    PS_IDLE  = 2'd0,
    PS_GUARD = 2'd1,
    PS_DRIVE = 2'd2,
    PS_COOL  = 2'd3
  } prot_st_e;

  function automatic int max3(input int a, input int b, input int c);
    int m;
    m = (a > b) ? a : b;
    return (m > c) ? m : c;
  endfunction

  function automatic int cnt_width(input int top);
    int w;
    w = $clog2(top + 1);
    return (w < 1) ? 1 : w;
  endfunction

  function automatic logic in_protect(input prot_st_e s);
    return s != PS_IDLE;
  endfunction
endpackage

// File: rtl/hlp_delay.sv
module hlp_delay #(
  parameter int W = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         tick_i,
  input  logic         load_i,
  input  logic [W-1:0] len_i,
  output logic         done_o
);
  logic [W-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                        cnt_q <= '0;
    else if (load_i)                   cnt_q <= len_i;
    else if (tick_i && cnt_q != '0)    cnt_q <= cnt_q - W'(1);
  end

  assign done_o = (cnt_q == '0);

  a_r10_no_tick_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (!load_i && !tick_i) |=> $stable(cnt_q));
  a_r10_tick_steps: assert property (@(posedge clk) disable iff (!rst_n)
    (!load_i && tick_i && cnt_q != '0) |=> (cnt_q == $past(cnt_q) - W'(1)));
endmodule

// File: rtl/hlp_meas.sv
module hlp_meas #(
  parameter int W      = 4,
  parameter int SETTLE = 5
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tick_i,
  input  logic start_i,
  input  logic det_low_i,
  output logic det_en_o,
  output logic sample_o,
  output logic low_flag_o
);
  logic busy_q;
  logic low_q;
  logic settle_done;
  logic launch;

  assign launch   = !busy_q && start_i;
  assign sample_o = busy_q && settle_done;

  hlp_delay #(.W(W)) i_settle (
    .clk    (clk),
    .rst_n  (rst_n),
    .tick_i (tick_i),
    .load_i (launch),
    .len_i  (W'(SETTLE)),
    .done_o (settle_done)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      low_q  <= 1'b0;
    end else begin
      if (launch)        busy_q <= 1'b1;
      else if (sample_o) busy_q <= 1'b0;
      if (sample_o)      low_q  <= det_low_i;
    end
  end

  assign det_en_o   = busy_q;
  assign low_flag_o = low_q;

  a_r2_enable_drops_after_settle: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(det_en_o) |-> $past(settle_done));
  a_r3_flag_moves_on_sample_only: assert property (@(posedge clk) disable iff (!rst_n)
    !sample_o |=> $stable(low_flag_o));
  a_r2_sample_needs_enable: assert property (@(posedge clk) disable iff (!rst_n)
    sample_o |-> det_en_o);
endmodule

// File: rtl/hlp_fsm.sv
module hlp_fsm
  import hlp_pkg::*;
#(
  parameter int W     = 6,
  parameter int GUARD = 10,
  parameter int COOL  = 40
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tick_i,
  input  logic heavy_req_i,
  input  logic heavy_done_i,
  input  logic sample_i,
  input  logic sample_low_i,
  input  logic low_flag_i,
  output logic protect_o,
  output logic drive_ok_o
);
  prot_st_e     st_q, st_d;
  logic         win_done;
  logic         win_load;
  logic [W-1:0] win_len;

  logic enter_evt;
  logic guard_done;
  logic cool_done;
  logic relapse_evt;
  logic resume_evt;

  assign enter_evt   = (st_q == PS_IDLE) && (heavy_req_i || (sample_i && sample_low_i));
  assign guard_done  = (st_q == PS_GUARD) && win_done;
  assign resume_evt  = (st_q == PS_COOL) && heavy_req_i;
  assign cool_done   = (st_q == PS_COOL) && !heavy_req_i && win_done;
  assign relapse_evt = cool_done && low_flag_i;

  always_comb begin
    st_d     = st_q;
    win_load = 1'b0;
    win_len  = W'(GUARD);
    unique case (st_q)
      PS_IDLE: if (enter_evt) begin
        st_d     = PS_GUARD;
        win_load = 1'b1;
      end
      PS_GUARD: if (guard_done) st_d = PS_DRIVE;
      PS_DRIVE: if (heavy_done_i) begin
        st_d     = PS_COOL;
        win_load = 1'b1;
        win_len  = W'(COOL);
      end
      PS_COOL: begin
        if (resume_evt) st_d = PS_DRIVE;
        else if (relapse_evt) begin
          win_load = 1'b1;
          win_len  = W'(COOL);
        end else if (cool_done) st_d = PS_IDLE;
      end
      default: st_d = PS_IDLE;
    endcase
  end

  hlp_delay #(.W(W)) i_window (
    .clk    (clk),
    .rst_n  (rst_n),
    .tick_i (tick_i),
    .load_i (win_load),
    .len_i  (win_len),
    .done_o (win_done)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) st_q <= PS_IDLE;
    else        st_q <= st_d;
  end

  assign protect_o  = in_protect(st_q);
  assign drive_ok_o = (st_q == PS_DRIVE);

  a_r11_permit_inside_protect: assert property (@(posedge clk) disable iff (!rst_n)
    drive_ok_o |-> protect_o);
  a_r6_permit_after_guard: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(drive_ok_o) |-> $past(guard_done || resume_evt));
  a_r7_exit_from_cooldown: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(protect_o) |-> $past(cool_done && !low_flag_i));
  a_r5_request_enters: assert property (@(posedge clk) disable iff (!rst_n)
    (!protect_o && heavy_req_i) |=> (protect_o && !drive_ok_o));
  a_r8_resume_immediate: assert property (@(posedge clk) disable iff (!rst_n)
    resume_evt |=> drive_ok_o);
  a_r9_relapse_holds: assert property (@(posedge clk) disable iff (!rst_n)
    relapse_evt |=> (protect_o && !drive_ok_o));
endmodule

// File: rtl/hlp_ctrl.sv
module hlp_ctrl #(
  parameter int SETTLE_TICKS = 5,
  parameter int GUARD_TICKS  = 10,
  parameter int COOL_TICKS   = 40
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tick_i,
  input  logic meas_req_i,
  input  logic det_low_i,
  input  logic heavy_req_i,
  input  logic heavy_done_i,
  output logic det_en_o,
  output logic protect_o,
  output logic drive_ok_o
);
  localparam int CNT_W = hlp_pkg::cnt_width(
    hlp_pkg::max3(SETTLE_TICKS, GUARD_TICKS, COOL_TICKS));

  logic sample_evt;
  logic low_flag;

  hlp_meas #(.W(CNT_W), .SETTLE(SETTLE_TICKS)) i_meas (
    .clk        (clk),
    .rst_n      (rst_n),
    .tick_i     (tick_i),
    .start_i    (meas_req_i),
    .det_low_i  (det_low_i),
    .det_en_o   (det_en_o),
    .sample_o   (sample_evt),
    .low_flag_o (low_flag)
  );

  hlp_fsm #(.W(CNT_W), .GUARD(GUARD_TICKS), .COOL(COOL_TICKS)) i_fsm (
    .clk          (clk),
    .rst_n        (rst_n),
    .tick_i       (tick_i),
    .heavy_req_i  (heavy_req_i),
    .heavy_done_i (heavy_done_i),
    .sample_i     (sample_evt),
    .sample_low_i (det_low_i),
    .low_flag_i   (low_flag),
    .protect_o    (protect_o),
    .drive_ok_o   (drive_ok_o)
  );

  a_r3_low_entry_needs_sample: assert property (@(posedge clk) disable iff (!rst_n)
    (!protect_o && !heavy_req_i && !sample_evt) |=> !protect_o);
endmodule

// File: tb/test_hlp_ctrl.sv
module test_hlp_ctrl;
  localparam int ST = 5;
  localparam int GD = 10;
  localparam int CL = 40;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic tick = 1'b0, meas_req = 1'b0, det_low = 1'b0;
  logic heavy_req = 1'b0, heavy_done = 1'b0;
  logic det_en, protect, drive_ok;

  int total = 0;
  int bad = 0;
  int cyc = 0;
  bit done_flag = 1'b0;

  always #10 clk = ~clk;

  hlp_ctrl #(.SETTLE_TICKS(ST), .GUARD_TICKS(GD), .COOL_TICKS(CL)) i_hlp_ctrl (
    .clk(clk), .rst_n(rst_n), .tick_i(tick), .meas_req_i(meas_req),
    .det_low_i(det_low), .heavy_req_i(heavy_req), .heavy_done_i(heavy_done),
    .det_en_o(det_en), .protect_o(protect), .drive_ok_o(drive_ok));

  // behavioural reference: m_busy/m_left for measurement, p_mode/p_left for protection
  int  m_busy = 0, m_left = 0, p_mode = 0, p_left = 0;
  bit  m_low = 1'b0;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_busy = 0; m_left = 0; p_mode = 0; p_left = 0; m_low = 1'b0;
    end else begin
      bit sampled;
      bit old_low;
      sampled = (m_busy == 1) && (m_left == 0);
      old_low = m_low;
      case (p_mode)
        0: if (heavy_req || (sampled && det_low)) begin p_mode = 1; p_left = GD; end
        1: if (p_left == 0) p_mode = 2; else if (tick) p_left--;
        2: if (heavy_done) begin p_mode = 3; p_left = CL; end
        default: begin
          if (heavy_req) p_mode = 2;
          else if (p_left == 0) begin
            if (old_low) p_left = CL; else p_mode = 0;
          end else if (tick) p_left--;
        end
      endcase
      if (m_busy == 0) begin
        if (meas_req) begin m_busy = 1; m_left = ST; end
      end else if (m_left == 0) begin
        m_low = det_low; m_busy = 0;
      end else if (tick) m_left--;
    end
  end

  task automatic chk(input string req, input logic act, input logic exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%0b exp=%0b at cycle %0d", req, act, exp, cyc);
    end
  endtask

  always @(negedge clk) begin
    cyc++;
    if (rst_n && !done_flag) begin
      chk("R2 det_en vs model", det_en, m_busy == 1);
      chk("R4 protect vs model", protect, p_mode != 0);
      chk("R6 drive_ok vs model", drive_ok, p_mode == 2);
      chk("R11 permit within protect", drive_ok && !protect, 1'b0);
    end
    if (cyc > 150000 && !done_flag) begin
      done_flag = 1'b1;
      bad++; total++;
      $display("FAIL watchdog expired");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  task automatic ticks(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); tick = 1'b1;
      @(negedge clk); tick = 1'b0;
    end
  endtask

  task automatic pulse_meas();
    @(negedge clk); meas_req = 1'b1; @(negedge clk); meas_req = 1'b0;
  endtask
  task automatic pulse_req();
    @(negedge clk); heavy_req = 1'b1; @(negedge clk); heavy_req = 1'b0;
  endtask
  task automatic pulse_done();
    @(negedge clk); heavy_done = 1'b1; @(negedge clk); heavy_done = 1'b0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk("R1 reset det_en", det_en, 1'b0);
    chk("R1 reset protect", protect, 1'b0);
    chk("R1 reset drive_ok", drive_ok, 1'b0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    chk("R1 idle after reset", protect, 1'b0);

    // R2/R3: high measurement, det_low toggled while settling
    pulse_meas();
    chk("R2 enable on request", det_en, 1'b1);
    for (int i = 0; i < 4; i++) begin @(negedge clk); det_low = ~det_low; end
    chk("R3 early low ignored", protect, 1'b0);
    det_low = 1'b0;
    ticks(ST);
    chk("R2 enable held to count end", det_en, 1'b1);
    @(negedge clk);
    chk("R2 enable dropped", det_en, 1'b0);
    chk("R4 high reading stays normal", protect, 1'b0);

    // R4/R6: low measurement, guard window
    pulse_meas();
    det_low = 1'b1;
    ticks(ST);
    @(negedge clk);
    det_low = 1'b0;
    chk("R4 low reading protects", protect, 1'b1);
    repeat (5) @(negedge clk);
    chk("R10 no ticks no permit", drive_ok, 1'b0);
    pulse_done();
    chk("R10 done outside drive ignored", protect, 1'b1);
    ticks(GD - 1);
    chk("R6 permit not before guard", drive_ok, 1'b0);
    ticks(1);
    chk("R6 permit one cycle late", drive_ok, 1'b0);
    @(negedge clk);
    chk("R6 permit after guard", drive_ok, 1'b1);
    pulse_req();
    chk("R10 request in drive ignored", drive_ok, 1'b1);

    // R7/R9: cooldown with low flag outstanding
    pulse_done();
    chk("R7 done clears permit", drive_ok, 1'b0);
    chk("R7 protect kept", protect, 1'b1);
    ticks(CL);
    @(negedge clk);
    repeat (2) @(negedge clk);
    chk("R9 low keeps protection", protect, 1'b1);
    pulse_meas();
    ticks(ST);
    @(negedge clk);
    ticks(CL);
    @(negedge clk);
    chk("R9 high reading releases", protect, 1'b0);

    // R5/R8
    @(negedge clk); heavy_req = 1'b1; meas_req = 1'b1;
    @(negedge clk); heavy_req = 1'b0; meas_req = 1'b0;
    chk("R5 request protects", protect, 1'b1);
    chk("R5 no permit yet", drive_ok, 1'b0);
    ticks(GD);
    @(negedge clk);
    chk("R6 permit after request guard", drive_ok, 1'b1);
    pulse_done();
    ticks(CL / 2);
    pulse_req();
    chk("R8 resume without guard", drive_ok, 1'b1);
    pulse_done();
    ticks(CL);
    @(negedge clk);
    chk("R7 exit after cool", protect, 1'b0);

    // R5 priority: request coinciding with a completing high measurement
    pulse_meas();
    ticks(ST);
    heavy_req = 1'b1;
    @(negedge clk); heavy_req = 1'b0;
    chk("R5 request wins over sample", protect, 1'b1);

    // random phase, model compared every cycle
    for (int i = 0; i < 6000; i++) begin
      @(negedge clk);
      tick       = ($urandom_range(0, 1) == 0);
      meas_req   = ($urandom_range(0, 7) == 0);
      heavy_req  = ($urandom_range(0, 59) == 0);
      heavy_done = ($urandom_range(0, 19) == 0);
      det_low    = ($urandom_range(0, 2) == 0);
    end
    @(negedge clk);
    tick = 1'b0; meas_req = 1'b0; heavy_req = 1'b0; heavy_done = 1'b0; det_low = 1'b0;
    repeat (2) @(negedge clk);
    done_flag = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule